// File: doc/BRIEF.md
# Colour Subcarrier Phase Generator

This block produces the running phase of the colour subcarrier for a composite video encoder, together with sine and cosine samples that the chroma modulator downstream multiplies with the colour-difference signals. A 32-bit accumulator adds an increment on every clock. Software sets the increment through four byte registers. A fifth register holds a phase offset that rotates the looked-up samples without disturbing the accumulator. The samples come from a quarter-wave table whose entries are computed when the design is elaborated.

A single external pin, `sc_pin`, is given one of two functions by `pin_mode`. In subcarrier-reset mode a rising edge arms a clear. The clear takes effect at the next field-start strobe, and the accumulator then returns to zero, which is the field-0 phase. In real-time-control mode the pin carries a serial frame from an external decoder. The frame begins with a rising start edge and holds 67 bit cells of two clocks each. Bits 0 to 21 form a frequency word. That word is installed as the increment only on a line-start strobe, so the frequency never changes in the middle of a line.

The pin logic is a state machine with these states:
- `PS_IDLE`: the pin is unused.
- `PS_SR_WATCH`: the block waits for a reset edge.
- `PS_SR_ARMED`: an edge has been seen and the block waits for the field start.
- `PS_RTC_HUNT`: the block waits for a frame start edge.
- `PS_RTC_CELL_A`: the first clock of a bit cell.
- `PS_RTC_CELL_B`: the second clock of a bit cell, where the bit is sampled.

The transitions are:
- IDLE goes to WATCH when the mode is reset, and to HUNT when the mode is serial.
- WATCH goes to ARMED on a rising edge.
- ARMED goes to WATCH on a field start, and clears the phase as it does so.
- HUNT goes to CELL_A on a rising edge.
- CELL_A always goes to CELL_B.
- CELL_B goes back to CELL_A, or goes to HUNT after the last cell.
- From any non-idle state, the block returns to IDLE whenever `pin_mode` leaves that state's family.

Top module: `chroma_dds`

## Requirements
- R1: While `rst_n` is low, and afterwards until any register is written, `phase_out` is 0 and stays 0. Both register banks reset to zero.
- R2: A write with `reg_addr` 0, 1, 2 or 3 loads bits 7:0, 15:8, 23:16 or 31:24 of the frequency word. Outside serial mode, `phase_out` grows by exactly the frequency word, modulo 2^32, on each clock after the write.
- R3: A write to `reg_addr` 4 sets an 8-bit offset. The offset is added to `phase_out[31:24]` before the lookup and never changes the accumulator.
- R4: With p = (`phase_out[31:24]` + offset) mod 256, `sin_out` lies within 2 of round(511·sin(2π(p+0.5)/256)), as a signed 10-bit value. `cos_out` follows the same formula using p+64.
- R5: `pin_mode` 2'b01 selects subcarrier reset and 2'b10 selects serial control. With 2'b00 or 2'b11, edges on `sc_pin` and field-start strobes leave the phase stepping normally.
- R6: In reset mode, a rising edge on `sc_pin` does not clear the phase at once. The first `field_start` strobe on a later clock clears `phase_out` to 0 at that clock edge. An edge on the same clock as a `field_start` defers the clear to the next strobe, and a strobe that has no prior edge has no effect.
- R7: A serial frame starts on a rising edge of `sc_pin`. Bit k is sampled on the second clock of cell k, where cell 0 begins on the clock after the start edge. Bits 0 to 21, least significant first, form word W, and the increment becomes W·2^10.
- R8: In serial mode the increment changes only on a `line_start` clock, when a captured word is waiting. The frequency registers are ignored, and the increment before the first word is 0.
- R9: A frame is 67 cells long. Rising edges inside it are data, and the next frame is recognised only after the 67th cell.
- R10: A `line_start` that arrives before bit 21 of a new frame has been sampled keeps the previous increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select (0–3 frequency bytes, 4 offset) |
| reg_wdata | input | 8 | Register write data |
| pin_mode | input | 2 | Function of the multi-purpose pin |
| sc_pin | input | 1 | Multi-purpose reset / serial control pin |
| field_start | input | 1 | One-clock strobe at the start of a field |
| line_start | input | 1 | One-clock strobe at the start of a line |
| phase_out | output | 32 | Accumulator phase |
| sin_out | output | 10 | Signed sine sample |
| cos_out | output | 10 | Signed cosine sample |

## Verification
The pin edge that arms a reset and the field-start strobe that would apply it can land on the same clock. The bench raises `sc_pin` and `field_start` together and expects the phase to keep stepping by the frequency word through that strobe, then expects a zero after the next strobe alone. A second collision sets the line-start strobe against a serial frame still in flight: a strobe during cell 5 must leave the old increment, and only a strobe after the frame may install the new word.

// File: rtl/chroma_dds_pkg.sv
`timescale 1ns/1ps
package chroma_dds_pkg;

    typedef enum logic [1:0] {
        PM_OFF_A   = 2'b00,
        PM_SCRESET = 2'b01,
        PM_RTC     = 2'b10,
        PM_OFF_B   = 2'b11
    } pin_mode_e;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_SR_WATCH,
        PS_SR_ARMED,
        PS_RTC_HUNT,
        PS_RTC_CELL_A,
        PS_RTC_CELL_B
    } pin_state_e;

endpackage

// File: rtl/chroma_dds_pinfsm.sv
`timescale 1ns/1ps
module chroma_dds_pinfsm
    import chroma_dds_pkg::*;
#(
    parameter int RTC_W     = 22,
    parameter int FRAME_LEN = 67
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       pin_mode,
    input  logic             sc_pin,
    input  logic             field_start,
    input  logic             line_start,
    output logic             clr_phase,
    output logic [RTC_W-1:0] rtc_word
);
    localparam int CNT_W = $clog2(FRAME_LEN + 1);

    pin_state_e       state_q, state_d;
    logic             pin_d;
    logic             rise;
    logic             mode_sr, mode_rtc;
    logic [CNT_W-1:0] bit_cnt;
    logic [RTC_W-1:0] shreg, cap_q;
    logic             cap_vld;
    logic             last_cell, last_word_bit;

    assign rise          = sc_pin & ~pin_d;
    assign mode_sr       = (pin_mode_e'(pin_mode) == PM_SCRESET);
    assign mode_rtc      = (pin_mode_e'(pin_mode) == PM_RTC);
    assign last_cell     = (bit_cnt == CNT_W'(FRAME_LEN - 1));
    assign last_word_bit = (bit_cnt == CNT_W'(RTC_W - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE: begin
                if (mode_sr)       state_d = PS_SR_WATCH;
                else if (mode_rtc) state_d = PS_RTC_HUNT;
            end
            PS_SR_WATCH: begin
                if (!mode_sr)  state_d = PS_IDLE;
                else if (rise) state_d = PS_SR_ARMED;
            end
            PS_SR_ARMED: begin
                if (!mode_sr)         state_d = PS_IDLE;
                else if (field_start) state_d = PS_SR_WATCH;
            end
            PS_RTC_HUNT: begin
                if (!mode_rtc) state_d = PS_IDLE;
                else if (rise) state_d = PS_RTC_CELL_A;
            end
            PS_RTC_CELL_A: begin
                if (!mode_rtc) state_d = PS_IDLE;
                else           state_d = PS_RTC_CELL_B;
            end
            PS_RTC_CELL_B: begin
                if (!mode_rtc)      state_d = PS_IDLE;
                else if (last_cell) state_d = PS_RTC_HUNT;
                else                state_d = PS_RTC_CELL_A;
            end
            default: state_d = PS_IDLE;
        endcase
    end

    // clear request: armed and the field begins
    assign clr_phase = (state_q == PS_SR_ARMED) && field_start && mode_sr;

    // outputs and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_d    <= 1'b0;
            bit_cnt  <= '0;
            shreg    <= '0;
            cap_q    <= '0;
            cap_vld  <= 1'b0;
            rtc_word <= '0;
        end else begin
            pin_d <= sc_pin;
            if (line_start && cap_vld && mode_rtc) begin
                rtc_word <= cap_q;
                cap_vld  <= 1'b0;
            end
            if (state_q == PS_RTC_CELL_B && mode_rtc) begin
                if (bit_cnt < CNT_W'(RTC_W)) shreg <= {sc_pin, shreg[RTC_W-1:1]};
                if (last_word_bit) begin
                    cap_q   <= {sc_pin, shreg[RTC_W-1:1]};
                    cap_vld <= 1'b1;
                end
                bit_cnt <= last_cell ? '0 : bit_cnt + 1'b1;
            end else if (state_q != PS_RTC_CELL_A) begin
                bit_cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/chroma_dds_acc.sv
`timescale 1ns/1ps
module chroma_dds_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [ACC_W-1:0] inc,
    output logic [ACC_W-1:0] phase
);
    always_ff @(posedge clk) begin
        if (!rst_n)   phase <= '0;
        else if (clr) phase <= '0;
        else          phase <= phase + inc;
    end
endmodule

// File: rtl/chroma_dds_sine.sv
`timescale 1ns/1ps
module chroma_dds_sine #(
    parameter int IDX_W = 6,
    parameter int OUT_W = 10
) (
    input  logic [IDX_W+1:0]        ph,
    output logic signed [OUT_W-1:0] val
);
    localparam int N     = 1 << IDX_W;
    localparam int MAG_W = OUT_W - 1;
    localparam longint AMP = (64'sd1 <<< MAG_W) - 1;

    // odd polynomial for sin(pi/2 * x), coefficients in Q16, x in Q16
    function automatic int quarter_sine(input int i);
        longint x, x2, x3, x5, x7, acc;
        x   = (longint'(2 * i + 1) * 64'sd65536) / longint'(2 * N);
        x2  = (x * x) >>> 16;
        x3  = (x2 * x) >>> 16;
        x5  = (x3 * x2) >>> 16;
        x7  = (x5 * x2) >>> 16;
        acc = 64'sd102944 * x - 64'sd42334 * x3 + 64'sd5223 * x5 - 64'sd307 * x7;
        return int'((acc * AMP + (64'sd1 <<< 31)) >>> 32);
    endfunction

    logic [MAG_W-1:0] rom [N];

    for (genvar gi = 0; gi < N; gi++) begin : g_rom
        assign rom[gi] = MAG_W'(quarter_sine(gi));
    end

    logic [1:0]       quad;
    logic [IDX_W-1:0] idx, sel;
    logic [MAG_W-1:0] mag;

    assign quad = ph[IDX_W+1:IDX_W];
    assign idx  = ph[IDX_W-1:0];
    assign sel  = quad[0] ? ~idx : idx;
    assign mag  = rom[sel];
    assign val  = quad[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
endmodule

// File: rtl/chroma_dds.sv
`timescale 1ns/1ps
module chroma_dds
    import chroma_dds_pkg::*;
#(
    parameter int ACC_W     = 32,
    parameter int REG_AW    = 3,
    parameter int IDX_W     = 6,
    parameter int OUT_W     = 10,
    parameter int RTC_W     = 22,
    parameter int FRAME_LEN = 67
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic [REG_AW-1:0]       reg_addr,
    input  logic [7:0]              reg_wdata,
    input  logic [1:0]              pin_mode,
    input  logic                    sc_pin,
    input  logic                    field_start,
    input  logic                    line_start,
    output logic [ACC_W-1:0]        phase_out,
    output logic signed [OUT_W-1:0] sin_out,
    output logic signed [OUT_W-1:0] cos_out
);
    localparam int NB       = ACC_W / 8;
    localparam int LUT_PH_W = IDX_W + 2;
    localparam int QUARTER  = 1 << IDX_W;

    logic [ACC_W-1:0] freq_q;
    logic [7:0]       ofs_q;
    logic [ACC_W-1:0] inc_sel;
    logic             clr_phase;
    logic [RTC_W-1:0] rtc_word;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_q <= '0;
            ofs_q  <= '0;
        end else if (reg_wr) begin
            for (int b = 0; b < NB; b++) begin
                if (reg_addr == REG_AW'(b)) freq_q[b*8 +: 8] <= reg_wdata;
            end
            if (reg_addr == REG_AW'(NB)) ofs_q <= reg_wdata;
        end
    end

    chroma_dds_pinfsm #(.RTC_W(RTC_W), .FRAME_LEN(FRAME_LEN)) u_pin (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_mode   (pin_mode),
        .sc_pin     (sc_pin),
        .field_start(field_start),
        .line_start (line_start),
        .clr_phase  (clr_phase),
        .rtc_word   (rtc_word)
    );

    assign inc_sel = (pin_mode_e'(pin_mode) == PM_RTC)
                   ? {rtc_word, {(ACC_W - RTC_W){1'b0}}}
                   : freq_q;

    chroma_dds_acc #(.ACC_W(ACC_W)) u_acc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr_phase),
        .inc  (inc_sel),
        .phase(phase_out)
    );

    logic [ACC_W-1:0]        rotated;
    logic [LUT_PH_W-1:0]     lut_ph  [2];
    logic signed [OUT_W-1:0] lut_val [2];

    assign rotated   = phase_out + {ofs_q, {(ACC_W - 8){1'b0}}};
    assign lut_ph[0] = rotated[ACC_W-1 -: LUT_PH_W];
    assign lut_ph[1] = rotated[ACC_W-1 -: LUT_PH_W] + LUT_PH_W'(QUARTER);

    for (genvar g = 0; g < 2; g++) begin : g_ch
        chroma_dds_sine #(.IDX_W(IDX_W), .OUT_W(OUT_W)) u_sine (
            .ph (lut_ph[g]),
            .val(lut_val[g])
        );
    end

    assign sin_out = lut_val[0];
    assign cos_out = lut_val[1];
endmodule

// File: rtl/chroma_dds_chk.sv
`timescale 1ns/1ps
module chroma_dds_chk #(
    parameter int ACC_W = 32,
    parameter int OUT_W = 10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [1:0]              pin_mode,
    input logic                    field_start,
    input logic                    line_start,
    input logic [ACC_W-1:0]        phase_out,
    input logic signed [OUT_W-1:0] sin_out,
    input logic signed [OUT_W-1:0] cos_out,
    input logic                    clr,
    input logic [ACC_W-1:0]        inc
);
    localparam int LIM = (1 << (OUT_W - 1)) - 1;

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr) |-> phase_out == $past(phase_out) + $past(inc));

    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> phase_out == '0);

    assert_clear_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> field_start);

    assert_clear_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> pin_mode == 2'b01);

    assert_line_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_mode == 2'b10 && $past(pin_mode) == 2'b10 && !$past(line_start))
        |-> $stable(inc));

    assert_sin_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sin_out >= -LIM && sin_out <= LIM && cos_out >= -LIM && cos_out <= LIM);
endmodule

bind chroma_dds chroma_dds_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_mode   (pin_mode),
    .field_start(field_start),
    .line_start (line_start),
    .phase_out  (phase_out),
    .sin_out    (sin_out),
    .cos_out    (cos_out),
    .clr        (clr_phase),
    .inc        (inc_sel)
);

// File: tb/chroma_dds_tb_top.sv
`timescale 1ns/1ps
module chroma_dds_tb_top;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [2:0]        reg_addr = '0;
    logic [7:0]        reg_wdata = '0;
    logic [1:0]        pin_mode = 2'b00;
    logic              sc_pin = 1'b0;
    logic              field_start = 1'b0;
    logic              line_start = 1'b0;
    logic [31:0]       phase_out;
    logic signed [9:0] sin_out, cos_out;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    chroma_dds dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .pin_mode(pin_mode), .sc_pin(sc_pin),
        .field_start(field_start), .line_start(line_start),
        .phase_out(phase_out), .sin_out(sin_out), .cos_out(cos_out)
    );

    typedef struct packed {
        logic [31:0] freq;
        logic [7:0]  ofs;
    } vec_t;

    localparam vec_t VEC [0:5] = '{
        '{32'h0100_0000, 8'h00},
        '{32'h0A3D_70A4, 8'h40},
        '{32'h21F0_7C1F, 8'h00},
        '{32'h2A09_8ACB, 8'h80},
        '{32'hFFFF_FFFF, 8'hC0},
        '{32'h0000_0001, 8'h20}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic write_freq(input logic [31:0] f);
        for (int b = 0; b < 4; b++) write_reg(3'(b), f[b*8 +: 8]);
    endtask

    task automatic check_step(input logic [31:0] exp, input string req);
        logic [31:0] pa, d;
        pa = phase_out;
        tick();
        d = phase_out - pa;
        check(d == exp, req, "phase step", longint'(d), longint'(exp));
    endtask

    function automatic int model(input logic [31:0] ph, input logic [7:0] o, input bit cosine);
        logic [31:0] full;
        logic [7:0]  p;
        real r;
        full = ph + {o, 24'h0};
        p = full[31:24];
        if (cosine) p = p + 8'd64;
        r = 511.0 * $sin(2.0 * 3.14159265358979 * (real'(p) + 0.5) / 256.0);
        return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
    endfunction

    task automatic check_lut(input logic [7:0] o);
        int es, ec, ds, dc;
        es = model(phase_out, o, 1'b0);
        ec = model(phase_out, o, 1'b1);
        ds = int'(sin_out) - es;
        dc = int'(cos_out) - ec;
        check(ds <= 2 && ds >= -2, "R4", "sine sample", longint'(sin_out), longint'(es));
        check(dc <= 2 && dc >= -2, "R4", "cosine sample", longint'(cos_out), longint'(ec));
    endtask

    task automatic pin_rise();
        sc_pin = 1'b0; tick();
        sc_pin = 1'b1; tick();
        sc_pin = 1'b0;
    endtask

    task automatic send_frame(input logic [66:0] bits, input int ls_cell);
        sc_pin = 1'b0; tick();
        sc_pin = 1'b1; tick();
        for (int i = 0; i < 67; i++) begin
            sc_pin = bits[i];
            line_start = (i == ls_cell);
            tick();
            line_start = 1'b0;
            tick();
        end
        sc_pin = 1'b0; tick();
    endtask

    task automatic pulse_line();
        line_start = 1'b1; tick();
        line_start = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] pa, f;
        logic [21:0] w1, w2;
        // R1: reset state
        repeat (4) tick();
        check(phase_out == 32'h0, "R1", "phase in reset", longint'(phase_out), 0);
        rst_n = 1'b1;
        repeat (3) tick();
        check(phase_out == 32'h0, "R1", "phase after reset", longint'(phase_out), 0);
        check_step(32'h0, "R1");

        // R2 R3 R4: vector table
        for (int v = 0; v < 6; v++) begin
            write_freq(VEC[v].freq);
            write_reg(3'd4, VEC[v].ofs);
            tick();
            for (int k = 0; k < 3; k++) begin
                check_lut(VEC[v].ofs);
                check_step(VEC[v].freq, "R2");
            end
            check_step(VEC[v].freq, "R3");
        end
        write_reg(3'd4, 8'h00);

        // R5: disabled modes ignore pin and field start
        f = 32'h0010_0000;
        write_freq(f);
        for (int m = 0; m < 2; m++) begin
            pin_mode = (m == 0) ? 2'b00 : 2'b11;
            repeat (2) tick();
            pin_rise();
            pa = phase_out;
            field_start = 1'b1; tick(); field_start = 1'b0;
            check(phase_out == pa + f, "R5", "disabled mode field start", longint'(phase_out), longint'(pa + f));
        end

        // R6: subcarrier reset mode
        pin_mode = 2'b01;
        repeat (2) tick();
        pin_rise();
        tick();
        check_step(f, "R6");
        check(phase_out != 32'h0, "R6", "no immediate clear", longint'(phase_out), 1);
        field_start = 1'b1; tick(); field_start = 1'b0;
        check(phase_out == 32'h0, "R6", "clear at field start", longint'(phase_out), 0);
        tick();
        check(phase_out == f, "R6", "step after clear", longint'(phase_out), longint'(f));
        // field start with nothing armed
        repeat (3) tick();
        pa = phase_out;
        field_start = 1'b1; tick(); field_start = 1'b0;
        check(phase_out == pa + f, "R6", "unarmed field start", longint'(phase_out), longint'(pa + f));
        // edge coinciding with field start
        sc_pin = 1'b0; tick();
        pa = phase_out;
        sc_pin = 1'b1; field_start = 1'b1; tick();
        field_start = 1'b0; sc_pin = 1'b0;
        check(phase_out == pa + f, "R6", "coincident edge deferred", longint'(phase_out), longint'(pa + f));
        repeat (3) tick();
        field_start = 1'b1; tick(); field_start = 1'b0;
        check(phase_out == 32'h0, "R6", "deferred clear", longint'(phase_out), 0);

        // R7 R8 R9 R10: serial control
        pin_mode = 2'b10;
        write_freq(32'h0);
        repeat (2) tick();
        check_step(32'h0, "R8");
        w1 = 22'h2AB3C5;
        send_frame({1'b0, {22{2'b10}}, w1}, -1);
        check_step(32'h0, "R8");
        pulse_line();
        tick();
        check_step({w1, 10'h0}, "R7");
        write_freq(32'h1234_5678);
        tick();
        check_step({w1, 10'h0}, "R8");
        w2 = 22'h15A0F3;
        send_frame({1'b1, {22{2'b01}}, w2}, 5);
        check_step({w1, 10'h0}, "R10");
        pulse_line();
        tick();
        check_step({w2, 10'h0}, "R9");
        pulse_line();
        tick();
        check_step({w2, 10'h0}, "R8");

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule